// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block steers operands around the write-back delay of a five-stage in-order pipeline. Each cycle it compares the destination register numbers held in the two later pipeline registers (the execute/memory boundary and the memory/write-back boundary) with the source register numbers of the instruction in execute. From those comparisons it builds one select code for each ALU operand and drives the selected value out through its own operand multiplexers. The value comes from the register file, from the execute/memory result or from the memory/write-back result.

A second pair of lanes serves the equality comparator in the decode stage, which resolves branches early. Those lanes can take a value only from the execute/memory result. The register file writes in the first half of a cycle and reads in the second, so a write-back in flight already reaches decode through the file itself. The block is purely combinational. The pipeline registers, register file, ALU and stall logic sit outside it.

Top module: `pipe_fwd_unit`

## Requirements
- R1: An execute select equals 2'b10 (execute/memory result) whenever the execute/memory write enable is high, its destination is nonzero, and the destination equals that operand's source number.
- R2: An execute select equals 2'b01 (memory/write-back result) when the memory/write-back write enable is high, its destination is nonzero and equals the source number, and the R1 condition does not hold for that operand.
- R3: When both producers match the same source, the execute/memory result wins (2'b10), since it is the younger value.
- R4: Register number 0 is never forwarded, and a producer whose write enable is low is never forwarded. In all other non-matching cases the select is 2'b00 (register file).
- R5: Operand A uses `ex_rs1` and operand B uses `ex_rs2`. The two selects are computed independently of each other.
- R6: `alu_op_a` and `alu_op_b` carry the register-file value for select 2'b00, `exm_result` for 2'b10 and `mwb_result` for 2'b01.
- R7: A decode select is 2'b10 when the execute/memory producer matches that decode source under the R1 rules. Otherwise it is 2'b00, even when the memory/write-back producer matches.
- R8: `cmp_op_a` and `cmp_op_b` carry the decode register-file value or `exm_result`, following their selects. `branch_eq` is high exactly when the two compared operands are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | First source register number of the instruction in execute |
| ex_rs2 | input | 5 | Second source register number of the instruction in execute |
| ex_rf_a | input | 32 | Register-file value read for ex_rs1 |
| ex_rf_b | input | 32 | Register-file value read for ex_rs2 |
| id_rs1 | input | 5 | First source register number of the instruction in decode |
| id_rs2 | input | 5 | Second source register number of the instruction in decode |
| id_rf_a | input | 32 | Register-file value read for id_rs1 |
| id_rf_b | input | 32 | Register-file value read for id_rs2 |
| exm_wr_en | input | 1 | Register write enable held in the execute/memory register |
| exm_rd | input | 5 | Destination number held in the execute/memory register |
| exm_result | input | 32 | Result held in the execute/memory register |
| mwb_wr_en | input | 1 | Register write enable held in the memory/write-back register |
| mwb_rd | input | 5 | Destination number held in the memory/write-back register |
| mwb_result | input | 32 | Result held in the memory/write-back register |
| ex_sel_a | output | 2 | Select for ALU operand A |
| ex_sel_b | output | 2 | Select for ALU operand B |
| alu_op_a | output | 32 | Forwarded ALU operand A |
| alu_op_b | output | 32 | Forwarded ALU operand B |
| id_sel_a | output | 2 | Select for comparator operand A |
| id_sel_b | output | 2 | Select for comparator operand B |
| cmp_op_a | output | 32 | Forwarded comparator operand A |
| cmp_op_b | output | 32 | Forwarded comparator operand B |
| branch_eq | output | 1 | Comparator operands are equal |

## Verification
Two functions can land on the same operand in one cycle: the forward at distance one (execute/memory) and the forward at distance two (memory/write-back). The bench sets both destinations to the same source number, with distinct result values, and confirms that the operand shows the execute/memory result. The same stimulus checks that the decode lanes ignore the memory/write-back match. Random register numbers are drawn from a small range, so collisions between both producers and one or both sources happen often. Each case is judged against selects and data that bench functions compute from the requirements.

// File: rtl/fwd_pkg.sv
// Shared encodings for the operand forwarding unit.
// Assumes two-bit select codes consumed by downstream operand muxes.
package fwd_pkg;

    // Operand source select codes; the bit positions are decoded by the muxes.
    typedef enum logic [1:0] {
        SRC_RFILE = 2'b00,
        SRC_MEMWB = 2'b01,
        SRC_EXMEM = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_match.sv
// Compares one producer destination against one consumer source.
// Assumes register 0 is hardwired to zero and is never a real producer.
module fwd_match #(
    parameter int REG_AW = 5
) (
    input  logic              wr_en,
    input  logic [REG_AW-1:0] dst,
    input  logic [REG_AW-1:0] src,
    output logic              hit
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Hit only for a live write to a nonzero register equal to the source.
    always_comb begin
        hit = wr_en && (dst != ZERO_REG) && (dst == src);
    end

endmodule

// File: rtl/fwd_select.sv
// Turns producer hits into a select code with younger-first priority.
// Assumes USE_MEMWB is 0 for lanes where the register file covers write-back.
module fwd_select
    import fwd_pkg::*;
#(
    parameter bit USE_MEMWB = 1'b1
) (
    input  logic     hit_exm,
    input  logic     hit_mwb,
    output fwd_sel_e sel
);

    generate
        if (USE_MEMWB) begin : g_two_src
            // Execute/memory first, then memory/write-back, else file.
            always_comb begin
                if (hit_exm)      sel = SRC_EXMEM;
                else if (hit_mwb) sel = SRC_MEMWB;
                else              sel = SRC_RFILE;
            end
        end else begin : g_one_src
            logic unused_mwb;
            // Memory/write-back hits are dropped on this lane.
            always_comb begin
                unused_mwb = hit_mwb;
                sel = hit_exm ? SRC_EXMEM : SRC_RFILE;
            end
        end
    endgenerate

endmodule

// File: rtl/fwd_opmux.sv
// Three-way operand multiplexer driven by a forwarding select code.
// Assumes an unused code falls back to the register file value.
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] exm_val,
    input  logic [DATA_W-1:0] mwb_val,
    output logic [DATA_W-1:0] op
);

    // Pick the operand source named by the select.
    always_comb begin
        unique case (sel)
            SRC_EXMEM: op = exm_val;
            SRC_MEMWB: op = mwb_val;
            default:   op = rf_val;
        endcase
    end

endmodule

// File: rtl/pipe_fwd_unit.sv
// Operand forwarding for a five-stage in-order pipeline: two execute
// lanes feed the ALU and two decode lanes feed the branch comparator.
// Assumes the register file writes before it reads in a cycle, so the
// decode lanes never take the memory/write-back result.
module pipe_fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [DATA_W-1:0] ex_rf_a,
    input  logic [DATA_W-1:0] ex_rf_b,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [DATA_W-1:0] id_rf_a,
    input  logic [DATA_W-1:0] id_rf_b,
    input  logic              exm_wr_en,
    input  logic [REG_AW-1:0] exm_rd,
    input  logic [DATA_W-1:0] exm_result,
    input  logic              mwb_wr_en,
    input  logic [REG_AW-1:0] mwb_rd,
    input  logic [DATA_W-1:0] mwb_result,
    output logic [1:0]        ex_sel_a,
    output logic [1:0]        ex_sel_b,
    output logic [DATA_W-1:0] alu_op_a,
    output logic [DATA_W-1:0] alu_op_b,
    output logic [1:0]        id_sel_a,
    output logic [1:0]        id_sel_b,
    output logic [DATA_W-1:0] cmp_op_a,
    output logic [DATA_W-1:0] cmp_op_b,
    output logic              branch_eq
);

    localparam int N_LANES  = 4;
    localparam int N_EXLANE = 2;

    logic [REG_AW-1:0] lane_src [N_LANES];
    logic [DATA_W-1:0] lane_rf  [N_LANES];
    logic [DATA_W-1:0] lane_op  [N_LANES];
    fwd_sel_e          lane_sel [N_LANES];

    // Gather lane sources: 0,1 are execute, 2,3 are decode.
    always_comb begin
        lane_src[0] = ex_rs1;
        lane_src[1] = ex_rs2;
        lane_src[2] = id_rs1;
        lane_src[3] = id_rs2;
        lane_rf[0]  = ex_rf_a;
        lane_rf[1]  = ex_rf_b;
        lane_rf[2]  = id_rf_a;
        lane_rf[3]  = id_rf_b;
    end

    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            logic hit_exm;
            logic hit_mwb;

            fwd_match #(.REG_AW(REG_AW)) u_m_exm (
                .wr_en (exm_wr_en),
                .dst   (exm_rd),
                .src   (lane_src[g]),
                .hit   (hit_exm)
            );

            fwd_match #(.REG_AW(REG_AW)) u_m_mwb (
                .wr_en (mwb_wr_en),
                .dst   (mwb_rd),
                .src   (lane_src[g]),
                .hit   (hit_mwb)
            );

            fwd_select #(.USE_MEMWB(g < N_EXLANE)) u_sel (
                .hit_exm (hit_exm),
                .hit_mwb (hit_mwb),
                .sel     (lane_sel[g])
            );

            fwd_opmux #(.DATA_W(DATA_W)) u_mux (
                .sel     (lane_sel[g]),
                .rf_val  (lane_rf[g]),
                .exm_val (exm_result),
                .mwb_val (mwb_result),
                .op      (lane_op[g])
            );
        end
    endgenerate

    // Drive the outputs from the lanes and compare the decode operands.
    always_comb begin
        ex_sel_a  = lane_sel[0];
        ex_sel_b  = lane_sel[1];
        id_sel_a  = lane_sel[2];
        id_sel_b  = lane_sel[3];
        alu_op_a  = lane_op[0];
        alu_op_b  = lane_op[1];
        cmp_op_a  = lane_op[2];
        cmp_op_b  = lane_op[3];
        branch_eq = (lane_op[2] == lane_op[3]);
    end

endmodule

// File: rtl/pipe_fwd_chk.sv
// Property checker for pipe_fwd_unit, bound to every instance.
// Assumes settled combinational values when the immediate checks run.
module pipe_fwd_chk #(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input logic [REG_AW-1:0] ex_rs1,
    input logic [REG_AW-1:0] ex_rs2,
    input logic [DATA_W-1:0] ex_rf_a,
    input logic [DATA_W-1:0] ex_rf_b,
    input logic [REG_AW-1:0] id_rs1,
    input logic [REG_AW-1:0] id_rs2,
    input logic [DATA_W-1:0] id_rf_a,
    input logic [DATA_W-1:0] id_rf_b,
    input logic              exm_wr_en,
    input logic [REG_AW-1:0] exm_rd,
    input logic [DATA_W-1:0] exm_result,
    input logic              mwb_wr_en,
    input logic [REG_AW-1:0] mwb_rd,
    input logic [DATA_W-1:0] mwb_result,
    input logic [1:0]        ex_sel_a,
    input logic [1:0]        ex_sel_b,
    input logic [DATA_W-1:0] alu_op_a,
    input logic [DATA_W-1:0] alu_op_b,
    input logic [1:0]        id_sel_a,
    input logic [1:0]        id_sel_b,
    input logic [DATA_W-1:0] cmp_op_a,
    input logic [DATA_W-1:0] cmp_op_b,
    input logic              branch_eq
);

    // Check the selects and data against the port-level rules.
    always_comb begin
        // R1
        exm_fwd_a_chk: assert (!(exm_wr_en && exm_rd != '0 && exm_rd == ex_rs1) || ex_sel_a == 2'b10);
        // R2
        mwb_fwd_b_chk: assert (!(mwb_wr_en && mwb_rd != '0 && mwb_rd == ex_rs2 &&
                                 !(exm_wr_en && exm_rd == ex_rs2)) || ex_sel_b == 2'b01);
        // R4
        zero_reg_chk: assert (ex_rs1 != '0 || ex_sel_a == 2'b00);
        // R6
        alu_data_chk: assert (ex_sel_a != 2'b01 || alu_op_a == mwb_result);
        // R7
        id_no_wb_chk: assert (id_sel_a != 2'b01 && id_sel_b != 2'b01);
        // R8
        cmp_eq_chk: assert (branch_eq == (cmp_op_a == cmp_op_b));
        // R8
        cmp_rf_chk: assert (id_sel_b != 2'b00 || cmp_op_b == id_rf_b);
    end

endmodule

bind pipe_fwd_unit pipe_fwd_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_fwd_chk (.*);

// File: tb/tb_pipe_fwd_unit.sv
`timescale 1ns/1ps
module tb_pipe_fwd_unit;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [4:0]  ex_rs1, ex_rs2, id_rs1, id_rs2, exm_rd, mwb_rd;
    logic [31:0] ex_rf_a, ex_rf_b, id_rf_a, id_rf_b, exm_result, mwb_result;
    logic        exm_wr_en, mwb_wr_en;
    logic [1:0]  ex_sel_a, ex_sel_b, id_sel_a, id_sel_b;
    logic [31:0] alu_op_a, alu_op_b, cmp_op_a, cmp_op_b;
    logic        branch_eq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    pipe_fwd_unit dut (.*);

    function automatic logic [1:0] exp_sel(input logic [4:0] src, input bit use_wb);
        if (exm_wr_en && exm_rd != 0 && exm_rd == src) return 2'b10;
        if (use_wb && mwb_wr_en && mwb_rd != 0 && mwb_rd == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_op(input logic [1:0] s, input logic [31:0] rf);
        return (s == 2'b10) ? exm_result : (s == 2'b01) ? mwb_result : rf;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every output against the bench model.
    task automatic check_all(input string tag);
        logic [1:0] sa, sb, da, db;
        logic [31:0] ca, cb;
        sa = exp_sel(ex_rs1, 1'b1);
        sb = exp_sel(ex_rs2, 1'b1);
        da = exp_sel(id_rs1, 1'b0);
        db = exp_sel(id_rs2, 1'b0);
        ca = exp_op(da, id_rf_a);
        cb = exp_op(db, id_rf_b);
        chk({tag, " R1/R2/R3/R4 sel_a"}, {30'd0, ex_sel_a}, {30'd0, sa});
        chk({tag, " R5 sel_b"}, {30'd0, ex_sel_b}, {30'd0, sb});
        chk({tag, " R6 op_a"}, alu_op_a, exp_op(sa, ex_rf_a));
        chk({tag, " R6 op_b"}, alu_op_b, exp_op(sb, ex_rf_b));
        chk({tag, " R7 id_sel_a"}, {30'd0, id_sel_a}, {30'd0, da});
        chk({tag, " R7 id_sel_b"}, {30'd0, id_sel_b}, {30'd0, db});
        chk({tag, " R8 cmp_a"}, cmp_op_a, ca);
        chk({tag, " R8 cmp_b"}, cmp_op_b, cb);
        chk({tag, " R8 eq"}, {31'd0, branch_eq}, {31'd0, ca == cb});
    endtask

    task automatic apply(input logic [4:0] r1, input logic [4:0] r2, input logic [4:0] d1,
                         input logic [4:0] d2, input logic ew, input logic [4:0] erd,
                         input logic mw, input logic [4:0] mrd);
        @(posedge clk);
        ex_rs1 = r1; ex_rs2 = r2; id_rs1 = d1; id_rs2 = d2;
        exm_wr_en = ew; exm_rd = erd; mwb_wr_en = mw; mwb_rd = mrd;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        ex_rf_a = 32'h1111_0001; ex_rf_b = 32'h2222_0002;
        id_rf_a = 32'h3333_0003; id_rf_b = 32'h4444_0004;
        exm_result = 32'hE0E0_0010; mwb_result = 32'hB0B0_0020;
        apply(0, 0, 0, 0, 0, 0, 0, 0);
        check_all("idle R4");
        // Distance 1: producer in execute/memory, R1.
        apply(5, 6, 7, 8, 1, 5, 0, 0);
        chk("R1 dist1", {30'd0, ex_sel_a}, 32'd2);
        check_all("dist1 R1");
        // Distance 2: producer in memory/write-back, R2 and R7 decode ignores it.
        apply(6, 9, 9, 3, 0, 0, 1, 9);
        chk("R2 dist2", {30'd0, ex_sel_b}, 32'd1);
        chk("R7 id ignores wb", {30'd0, id_sel_a}, 32'd0);
        check_all("dist2 R2");
        // Both producers match the same source, R3.
        apply(4, 4, 4, 4, 1, 4, 1, 4);
        chk("R3 both", alu_op_a, exm_result);
        check_all("both R3");
        // Register 0 never forwarded, R4.
        apply(0, 0, 0, 0, 1, 0, 1, 0);
        chk("R4 r0", alu_op_a, ex_rf_a);
        check_all("r0 R4");
        // Write enable low, R4.
        apply(3, 3, 3, 3, 0, 3, 0, 3);
        check_all("nowe R4");
        // Equal operands on the comparator via forwarding, R8.
        id_rf_b = exm_result;
        apply(1, 2, 12, 13, 1, 12, 0, 0);
        chk("R8 eq fwd", {31'd0, branch_eq}, 32'd1);
        check_all("eq R8");
        for (int i = 0; i < 400; i++) begin
            ex_rf_a = $urandom; ex_rf_b = $urandom; id_rf_a = $urandom;
            id_rf_b = (i % 5 == 0) ? exm_result : $urandom;
            exm_result = $urandom; mwb_result = $urandom;
            apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)));
            check_all("rand");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule